// File: doc/BRIEF.md
# Clocked Asynchronous DRAM Access Sequencer

This block sits between a simple request port and one asynchronous DRAM device. Each accepted request carries a flat word address, a write flag and write data. The sequencer splits the address into a row part and a column part and puts them, one after the other, on a shared multiplexed address bus. It then drives the active-low row strobe, column strobe, write strobe and output-enable strobe, so that the device sees a correctly ordered single access.

Every strobe edge lands on a controller clock edge, and the spacing between edges comes from integer cycle-count parameters. These cover the sense delay from row strobe to column strobe, the row restore time and the row precharge time. On a read, the data pins are sampled a fixed number of cycles after the column strobe falls. The captured word comes back with a one-cycle valid pulse.

Refresh is arbitrated outside the block. An arbitration hold input keeps the sequencer from starting a new access while another agent owns the device.

Top module: `async_dram_seq`

## Requirements
- R1: While reset is asserted and after it is released, rowStrbN, colStrbN, wrStrbN and outEnN are 1, dqDrive and rspValid are 0, and reqReady is 1 when accessHold is 0.
- R2: reqAddr bits [ROW_W+COL_W-1:COL_W] are the row and bits [COL_W-1:0] are the column. The row is on dramAddr when rowStrbN falls, and the zero-extended column is on dramAddr when colStrbN falls and stays there while colStrbN is low.
- R3: colStrbN falls exactly T_RCD clock cycles after rowStrbN falls.
- R4: colStrbN is low for exactly T_CL cycles and is never low while rowStrbN is high. rowStrbN is low for exactly max(T_RAS, T_RCD+T_CL) cycles, which is never less than T_RAS.
- R5: Between a rise of rowStrbN and its next fall, rowStrbN stays high for at least T_RP cycles.
- R6: For a write, wrStrbN is 0 and dqDrive is 1 at the colStrbN fall, dramDqOut equals the request's write data there, and outEnN stays 1.
- R7: For a read, wrStrbN is 1 and outEnN is 0 while colStrbN is low. dramDqIn is sampled on the clock edge T_CL cycles after the colStrbN fall, and rspValid is high for exactly one cycle with that word on rspData. That cycle follows the acceptance edge by 1+T_RCD+T_CL edges.
- R8: reqReady is 0 from the acceptance edge until precharge ends. It becomes 1 again 1+max(T_RAS,T_RCD+T_CL)+T_RP edges after acceptance.
- R9: While accessHold is 1, reqReady is 0, no request is accepted and rowStrbN stays 1, even with reqValid high.
- R10: A write never produces an rspValid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accessHold | input | 1 | Arbitration hold; blocks new accesses |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqAddr | input | ROW_W+COL_W | Flat word address {row, column} |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | One-cycle read data valid |
| rspData | output | DATA_W | Read data |
| dramAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| rowStrbN | output | 1 | Row strobe, active low |
| colStrbN | output | 1 | Column strobe, active low |
| wrStrbN | output | 1 | Write strobe, active low |
| outEnN | output | 1 | Device output enable, active low |
| dramDqOut | output | DATA_W | Data toward the device |
| dqDrive | output | 1 | Enables dramDqOut onto the data pins |
| dramDqIn | input | DATA_W | Data from the device |

## Verification
Writes and reads are sent to the corner addresses (all zeros and all ones). They also go to several columns within one row and to one column across several rows. These cases separate a swapped or truncated row/column split from a correct one, and read-back compares each word with what a bench-side device model stored. Alternating and walking data words expose lost or stuck data bits. Back-to-back requests probe the precharge window and the exact ready-return cycle. A request held off by accessHold shows that the arbitration input blocks acceptance instead of delaying it silently.

// File: rtl/async_dram_seq_pkg.sv
package async_dram_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ROWSET,
    PH_ACTIVE,
    PH_PRECHG
  } seqPhase_e;

  typedef struct packed {
    logic capture;   // latch the incoming request
    logic colSel;    // drive the column on the address bus
    logic drive;     // drive write data toward the device
    logic sample;    // capture device read data on this edge
  } seqStrobe_t;

endpackage

// File: rtl/adsControl.sv
module adsControl
  import async_dram_seq_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RAS = 7,
  parameter int T_RP  = 3,
  parameter int T_CL  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       accessHold,
  input  logic       reqValid,
  input  logic       curWrite,
  output logic       reqReady,
  output logic       rowStrbN,
  output logic       colStrbN,
  output logic       wrStrbN,
  output logic       outEnN,
  output seqStrobe_t strobe
);

  localparam int RAS_LOW = (T_RAS > T_RCD + T_CL) ? T_RAS : T_RCD + T_CL;
  localparam int MAX_CNT = (RAS_LOW > T_RP) ? RAS_LOW : T_RP;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  localparam logic [CNT_W-1:0] ONE_C     = CNT_W'(1);
  localparam logic [CNT_W-1:0] RCD_C     = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] CAS_END_C = CNT_W'(T_RCD + T_CL);
  localparam logic [CNT_W-1:0] SAMPLE_C  = CNT_W'(T_RCD + T_CL - 1);
  localparam logic [CNT_W-1:0] RAS_END_C = CNT_W'(RAS_LOW - 1);
  localparam logic [CNT_W-1:0] RP_END_C  = CNT_W'(T_RP - 1);

  seqPhase_e        phase;
  logic [CNT_W-1:0] phaseCnt;
  logic             accept;
  logic             inActive;
  logic             colPhase;
  logic             casWindow;

  assign accept = (phase == PH_IDLE) && reqValid && !accessHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      phaseCnt <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseCnt <= '0;
          if (accept) phase <= PH_ROWSET;
        end
        PH_ROWSET: begin
          phase    <= PH_ACTIVE;
          phaseCnt <= '0;
        end
        PH_ACTIVE: begin
          if (phaseCnt == RAS_END_C) begin
            phase    <= PH_PRECHG;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + ONE_C;
          end
        end
        PH_PRECHG: begin
          if (phaseCnt == RP_END_C) begin
            phase    <= PH_IDLE;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + ONE_C;
          end
        end
        default: begin
          phase    <= PH_IDLE;
          phaseCnt <= '0;
        end
      endcase
    end
  end

  assign inActive  = (phase == PH_ACTIVE);
  assign colPhase  = inActive && (phaseCnt >= ONE_C);
  assign casWindow = inActive && (phaseCnt >= RCD_C) && (phaseCnt < CAS_END_C);

  assign reqReady = (phase == PH_IDLE) && !accessHold;
  assign rowStrbN = !inActive;
  assign colStrbN = !casWindow;
  assign wrStrbN  = !(curWrite && colPhase && (phaseCnt < CAS_END_C));
  assign outEnN   = !(!curWrite && casWindow);

  always_comb begin
    strobe.capture = accept;
    strobe.colSel  = colPhase;
    strobe.drive   = curWrite && colPhase && (phaseCnt < CAS_END_C);
    strobe.sample  = !curWrite && inActive && (phaseCnt == SAMPLE_C);
  end

endmodule

// File: rtl/adsDatapath.sv
module adsDatapath
  import async_dram_seq_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  seqStrobe_t                       strobe,
  input  logic [ROW_W+COL_W-1:0]           reqAddr,
  input  logic                             reqWrite,
  input  logic [DATA_W-1:0]                reqWdata,
  input  logic [DATA_W-1:0]                dramDqIn,
  output logic                             curWrite,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dramAddr,
  output logic [DATA_W-1:0]                dramDqOut,
  output logic                             dqDrive,
  output logic                             rspValid,
  output logic [DATA_W-1:0]                rspData
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [ROW_W-1:0]  rowReg;
  logic [COL_W-1:0]  colReg;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg   <= '0;
      colReg   <= '0;
      dataReg  <= '0;
      curWrite <= 1'b0;
    end else if (strobe.capture) begin
      rowReg   <= reqAddr[ADDR_W-1:COL_W];
      colReg   <= reqAddr[COL_W-1:0];
      dataReg  <= reqWdata;
      curWrite <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.sample;
      if (strobe.sample) rspData <= dramDqIn;
    end
  end

  assign dramAddr  = strobe.colSel ? MUX_W'(colReg) : MUX_W'(rowReg);
  assign dramDqOut = dataReg;
  assign dqDrive   = strobe.drive;

endmodule

// File: rtl/async_dram_seq.sv
module async_dram_seq
  import async_dram_seq_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 5,
  parameter int DATA_W = 8,
  parameter int T_RCD  = 3,
  parameter int T_RAS  = 7,
  parameter int T_RP   = 3,
  parameter int T_CL   = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             accessHold,
  input  logic                             reqValid,
  output logic                             reqReady,
  input  logic [ROW_W+COL_W-1:0]           reqAddr,
  input  logic                             reqWrite,
  input  logic [DATA_W-1:0]                reqWdata,
  output logic                             rspValid,
  output logic [DATA_W-1:0]                rspData,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dramAddr,
  output logic                             rowStrbN,
  output logic                             colStrbN,
  output logic                             wrStrbN,
  output logic                             outEnN,
  output logic [DATA_W-1:0]                dramDqOut,
  output logic                             dqDrive,
  input  logic [DATA_W-1:0]                dramDqIn
);

  seqStrobe_t strobe;
  logic       curWrite;

  adsControl #(
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_CL(T_CL)
  ) control_i (
    .clk(clk), .rstN(rstN), .accessHold(accessHold), .reqValid(reqValid),
    .curWrite(curWrite), .reqReady(reqReady), .rowStrbN(rowStrbN),
    .colStrbN(colStrbN), .wrStrbN(wrStrbN), .outEnN(outEnN), .strobe(strobe)
  );

  adsDatapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .dramDqIn(dramDqIn),
    .curWrite(curWrite), .dramAddr(dramAddr), .dramDqOut(dramDqOut),
    .dqDrive(dqDrive), .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: rtl/adsChecker.sv
module adsChecker #(
  parameter int MUX_W = 6,
  parameter int T_RCD = 3,
  parameter int T_RAS = 7,
  parameter int T_RP  = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             rspValid,
  input logic [MUX_W-1:0] dramAddr,
  input logic             rowStrbN,
  input logic             colStrbN,
  input logic             wrStrbN,
  input logic             outEnN,
  input logic             dqDrive
);

  logic [7:0] lowCnt;
  logic [7:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= 8'hFF;
    end else if (!rowStrbN) begin
      lowCnt  <= (lowCnt == 8'hFF) ? lowCnt : lowCnt + 8'd1;
      highCnt <= '0;
    end else begin
      highCnt <= (highCnt == 8'hFF) ? highCnt : highCnt + 8'd1;
      lowCnt  <= '0;
    end
  end

  a_r3_sense_delay: assert property (@(posedge clk) disable iff (!rstN)
    $fell(colStrbN) |-> lowCnt >= 8'(T_RCD));

  a_r4_restore_time: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rowStrbN) |-> lowCnt >= 8'(T_RAS));

  a_r4_col_inside_row: assert property (@(posedge clk) disable iff (!rstN)
    rowStrbN |-> colStrbN);

  a_r5_precharge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rowStrbN) |-> highCnt >= 8'(T_RP));

  a_r2_col_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!colStrbN && $past(!colStrbN)) |-> $stable(dramAddr));

  a_r6_write_drive: assert property (@(posedge clk) disable iff (!rstN)
    (!colStrbN && !wrStrbN) |-> (dqDrive && outEnN));

  a_r7_read_enable: assert property (@(posedge clk) disable iff (!rstN)
    (!colStrbN && wrStrbN) |-> (!outEnN && !dqDrive));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  a_r8_busy_while_open: assert property (@(posedge clk) disable iff (!rstN)
    !rowStrbN |-> !reqReady);

endmodule

bind async_dram_seq adsChecker #(
  .MUX_W((ROW_W > COL_W) ? ROW_W : COL_W),
  .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)
) checker_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .dramAddr(dramAddr), .rowStrbN(rowStrbN), .colStrbN(colStrbN),
  .wrStrbN(wrStrbN), .outEnN(outEnN), .dqDrive(dqDrive)
);

// File: tb/async_dram_seq_tb_top.sv
`timescale 1ns/1ps
module async_dram_seq_tb_top;

  localparam int ROW_W   = 6;
  localparam int COL_W   = 5;
  localparam int DATA_W  = 8;
  localparam int T_RCD   = 3;
  localparam int T_RAS   = 7;
  localparam int T_RP    = 3;
  localparam int T_CL    = 2;
  localparam int RAS_LOW = (T_RAS > T_RCD + T_CL) ? T_RAS : T_RCD + T_CL;
  localparam int ADDR_W  = ROW_W + COL_W;
  localparam int MUX_W   = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              accessHold = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqWrite = 1'b0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              rspValid;
  logic [DATA_W-1:0] rspData;
  logic [MUX_W-1:0]  dramAddr;
  logic              rowStrbN, colStrbN, wrStrbN, outEnN, dqDrive;
  logic [DATA_W-1:0] dramDqOut;
  logic [DATA_W-1:0] dramDqIn = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_dram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_CL(T_CL)
  ) dut_i (
    .clk(clk), .rstN(rstN), .accessHold(accessHold), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData),
    .dramAddr(dramAddr), .rowStrbN(rowStrbN), .colStrbN(colStrbN),
    .wrStrbN(wrStrbN), .outEnN(outEnN), .dramDqOut(dramDqOut),
    .dqDrive(dqDrive), .dramDqIn(dramDqIn)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Device model and strobe-timing monitor, sampled on falling clock edges
  logic [DATA_W-1:0] model [0:(1<<ADDR_W)-1];
  logic [ROW_W-1:0]  expRow = '0;
  logic [COL_W-1:0]  expCol = '0;
  logic              expWr = 1'b0;
  logic [DATA_W-1:0] expData = '0;
  logic [ROW_W-1:0]  seenRow = '0;
  logic              prevRow = 1'b1, prevCol = 1'b1;
  int rowFallAt = 0, rowRiseAt = -1, colFallAt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!colStrbN && rowStrbN)
        check(1'b0, "R4 column strobe low while row strobe high", 0, 1);
      if (prevRow && !rowStrbN) begin
        rowFallAt = cyc;
        seenRow = dramAddr[ROW_W-1:0];
        check(dramAddr == MUX_W'(expRow), "R2 row address at row fall", dramAddr, expRow);
        if (rowRiseAt >= 0)
          check(rowFallAt - rowRiseAt >= T_RP, "R5 precharge window",
                rowFallAt - rowRiseAt, T_RP);
      end
      if (!prevRow && rowStrbN) begin
        rowRiseAt = cyc;
        check(rowRiseAt - rowFallAt == RAS_LOW, "R4 row strobe low time",
              rowRiseAt - rowFallAt, RAS_LOW);
      end
      if (prevCol && !colStrbN) begin
        colFallAt = cyc;
        check(colFallAt - rowFallAt == T_RCD, "R3 row-to-column delay",
              colFallAt - rowFallAt, T_RCD);
        check(dramAddr == MUX_W'(expCol), "R2 column address at column fall",
              dramAddr, expCol);
        check(wrStrbN == !expWr, "R6/R7 write strobe level", wrStrbN, !expWr);
        if (!wrStrbN) begin
          check(dqDrive && dramDqOut == expData, "R6 write data at column fall",
                {dqDrive, dramDqOut}, {1'b1, expData});
          check(outEnN == 1'b1, "R6 output enable stays high on write", outEnN, 1);
          model[{seenRow, dramAddr[COL_W-1:0]}] = dramDqOut;
        end else begin
          check(outEnN == 1'b0, "R7 output enable low on read", outEnN, 0);
          dramDqIn <= model[{seenRow, dramAddr[COL_W-1:0]}];
        end
      end
      if (!prevCol && colStrbN) begin
        check(cyc - colFallAt == T_CL, "R4 column strobe width", cyc - colFallAt, T_CL);
        dramDqIn <= 8'h3C;
      end
      prevRow = rowStrbN;
      prevCol = colStrbN;
    end
  end

  task automatic access(input bit wr, input logic [ADDR_W-1:0] addr,
                        input logic [DATA_W-1:0] data, input string name);
    int rspCount = 0;
    int rspAt = -1;
    int readyAt = -1;
    int waitCnt = 0;
    logic [DATA_W-1:0] got = '0;
    @(negedge clk);
    expRow = addr[ADDR_W-1:COL_W];
    expCol = addr[COL_W-1:0];
    expWr = wr;
    expData = data;
    reqAddr = addr;
    reqWrite = wr;
    reqWdata = data;
    reqValid = 1'b1;
    while (!reqReady && waitCnt < 50) begin
      @(negedge clk);
      waitCnt++;
    end
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr = ~addr;
    reqWdata = ~data;
    for (int k = 0; k <= 40; k++) begin
      if (rspValid) begin
        rspCount++;
        if (rspAt < 0) begin
          rspAt = k;
          got = rspData;
        end
      end
      if (reqReady && readyAt < 0) readyAt = k;
      if (k < 40) @(negedge clk);
    end
    if (wr) begin
      check(rspCount == 0, {"R10 no response for write ", name}, rspCount, 0);
    end else begin
      check(rspCount == 1, {"R7 single response pulse ", name}, rspCount, 1);
      check(rspAt == 1 + T_RCD + T_CL, {"R7 response latency ", name},
            rspAt, 1 + T_RCD + T_CL);
      check(got == data, {"R7 read data ", name}, got, data);
    end
    check(readyAt == 1 + RAS_LOW + T_RP, {"R8 ready return cycle ", name},
          readyAt, 1 + RAS_LOW + T_RP);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(rowStrbN && colStrbN && wrStrbN && outEnN, "R1 strobes high in reset",
          {rowStrbN, colStrbN, wrStrbN, outEnN}, 4'hF);
    check(!dqDrive && !rspValid, "R1 drive and response low in reset",
          {dqDrive, rspValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    check(rowStrbN && colStrbN && wrStrbN && outEnN, "R1 strobes idle after reset",
          {rowStrbN, colStrbN, wrStrbN, outEnN}, 4'hF);
  endtask

  task automatic testCorners();
    access(1'b1, '0, 8'h5A, "corner zero");
    access(1'b1, '1, 8'hC3, "corner ones");
    access(1'b0, '0, 8'h5A, "corner zero");
    access(1'b0, '1, 8'hC3, "corner ones");
  endtask

  task automatic testSameRow();
    for (int c = 0; c < 4; c++)
      access(1'b1, {6'd21, 5'(c * 7 + 1)}, 8'(8'h01 << c), "same row");
    for (int c = 0; c < 4; c++)
      access(1'b0, {6'd21, 5'(c * 7 + 1)}, 8'(8'h01 << c), "same row");
  endtask

  task automatic testSameCol();
    for (int r = 0; r < 4; r++)
      access(1'b1, {6'(r * 13 + 2), 5'd10}, 8'(8'hAA ^ (r << 4)), "same column");
    for (int r = 0; r < 4; r++)
      access(1'b0, {6'(r * 13 + 2), 5'd10}, 8'(8'hAA ^ (r << 4)), "same column");
  endtask

  task automatic testHold();
    @(negedge clk);
    accessHold = 1'b1;
    expRow = 6'd21;
    expCol = 5'd1;
    expWr = 1'b0;
    reqAddr = {6'd21, 5'd1};
    reqWrite = 1'b0;
    reqValid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!reqReady && rowStrbN, "R9 hold blocks acceptance",
            {reqReady, rowStrbN}, 2'b01);
    end
    reqValid = 1'b0;
    accessHold = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rowStrbN == 1'b1, "R9 held request was not taken", rowStrbN, 1);
    end
    access(1'b0, {6'd21, 5'd1}, 8'h01, "after hold");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testCorners();
    testSameRow();
    testSameCol();
    testHold();
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule